// File: doc/BRIEF.md
# Guarded Status Register

A single 8-bit volatile status register at one fixed address of a device's register space. It reports whether the device runs from its backup supply, carries two sticky alarm flags and a power-fail flag, and holds two write-enable latches. Together the latches gate every write the device may accept elsewhere. Memory-array writes need the first latch. Control-register writes need both latches. The second latch can only be armed once the first is set. It drops again when a nonvolatile write cycle finishes.

The serial front end drives a plain register port. It supplies an address, a write strobe with data, a read-open strobe and a read-close strobe for the status address. The read-close strobe marks the end of the last data bit. The block decides in the same cycle whether a write elsewhere is acknowledged and whether it starts a nonvolatile cycle. Alarm flags clear on a status read. Only flags already set when that read opened are cleared, so an alarm raised during the read is not lost.

Top module: `status_guard`

## Requirements
- R1: After reset `stat_q` reads 0x01. Bit 0 is the power-fail flag, and every latch and flag reads 0.
- R2: Bit 7 of `stat_q` shows `on_backup` as sampled on the previous clock edge. Writes to the status address never change it.
- R3: A status write of exactly 0x02 sets the write latch (bit 1). A status write of exactly 0x00 clears bit 1 and bit 2. Every other status write value leaves bit 1 unchanged.
- R4: A status write of exactly 0x06 sets the control latch (bit 2), but only while bit 1 is already 1. No other value sets bit 2. Bit 2 is never 1 while bit 1 is 0.
- R5: A `nv_done` pulse clears bit 2 on the next edge. It takes priority over a 0x06 write in the same cycle, and it leaves bit 1 unchanged.
- R6: A status write is always acknowledged (`wr_ack`=1) and never asserts `nv_start`.
- R7: A write to an array address (at or above 0x040) is acknowledged, and asserts `nv_start` in the same cycle, exactly when bit 1 is 1. Otherwise both outputs stay 0.
- R8: A write to a control address (below 0x03F) is acknowledged, and asserts `nv_start`, exactly when bits 1 and 2 are both 1.
- R9: An `alarm_hit[i]` pulse sets alarm flag i on the next edge. Flag 0 is bit 5 and flag 1 is bit 6.
- R10: A `rd_start` at the status address snapshots the alarm flags. The following `rd_end` clears only the snapshotted flags. A flag set after the snapshot survives, and so does a flag hit in the same cycle as `rd_end`. An `rd_end` with no open read changes nothing.
- R11: An acknowledged control write clears the power-fail flag on the next edge. Only reset sets it again.
- R12: Bits 4 and 3 of `stat_q` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W (12) | Address of the current access |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_wdata | input | 8 | Write data |
| rd_start | input | 1 | Opens a read at `reg_addr` |
| rd_end | input | 1 | Last data bit of an open status read |
| alarm_hit | input | 2 | Per-alarm match pulses |
| on_backup | input | 1 | High while running from the backup supply |
| nv_done | input | 1 | Nonvolatile write cycle finished |
| stat_q | output | 8 | Status register value |
| wr_ack | output | 1 | Current write is acknowledged |
| nv_start | output | 1 | Current write starts a nonvolatile cycle |
| we_open | output | 1 | Write latch state |
| ctl_open | output | 1 | Both latches set, so control writes are allowed |

## Verification
The assertions take the front end to be well behaved. `rd_end` follows a matching `rd_start`, and `nv_done` only follows an accepted write. The alarm and write checks also take every strobe to be a single-cycle pulse that is sampled on a clean edge. The stimulus drives each strobe for exactly one cycle, a few time units after the rising edge, and keeps the address stable for the whole access. It opens at most one read at a time. Every status byte value is swept from each reachable latch state.

// File: rtl/status_guard_pkg.sv
package status_guard_pkg;
  localparam int DW        = 8;
  localparam int NUM_ALM   = 2;
  localparam int B_BACKUP  = 7;
  localparam int B_ALM1    = 6;
  localparam int B_ALM0    = 5;
  localparam int B_CTL     = 2;
  localparam int B_WE      = 1;
  localparam int B_PFAIL   = 0;
  localparam logic [DW-1:0] MASK_WE   = DW'(1) << B_WE;
  localparam logic [DW-1:0] MASK_BOTH = (DW'(1) << B_WE) | (DW'(1) << B_CTL);

  typedef enum logic [1:0] {PAT_OTHER, PAT_WE_ON, PAT_BOTH_ON, PAT_CLEAR} wpat_e;
  typedef enum logic [1:0] {AK_STATUS, AK_CTRL, AK_ARRAY} akind_e;

  // Classify a whole byte written to the status address.
  function automatic wpat_e decode_pat(input logic [DW-1:0] d);
    if (d == '0)             return PAT_CLEAR;
    else if (d == MASK_WE)   return PAT_WE_ON;
    else if (d == MASK_BOTH) return PAT_BOTH_ON;
    else                     return PAT_OTHER;
  endfunction

  // Next value of a flag vector: a closing read drops the snapshotted
  // bits, and a fresh hit always wins.
  function automatic logic [NUM_ALM-1:0] alarm_next(
      input logic [NUM_ALM-1:0] flags,
      input logic [NUM_ALM-1:0] snap,
      input logic [NUM_ALM-1:0] hit,
      input logic               close_rd);
    logic [NUM_ALM-1:0] kept;
    kept = close_rd ? (flags & ~snap) : flags;
    return kept | hit;
  endfunction

  function automatic logic [DW-1:0] pack_status(
      input logic               backup,
      input logic [NUM_ALM-1:0] alm,
      input logic               ctl,
      input logic               we,
      input logic               pfail);
    logic [DW-1:0] v;
    v = '0;
    v[B_BACKUP] = backup;
    v[B_ALM1]   = alm[1];
    v[B_ALM0]   = alm[0];
    v[B_CTL]    = ctl;
    v[B_WE]     = we;
    v[B_PFAIL]  = pfail;
    return v;
  endfunction
endpackage

// File: rtl/sg_access_gate.sv
module sg_access_gate
  import status_guard_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] STAT_ADDR = 12'h03F,
  parameter logic [11:0] ARRAY_LO  = 12'h040
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              we_q,
  input  logic              ctl_q,
  output logic              stat_wr,
  output logic              ctl_wr_ok,
  output logic              ack,
  output logic              nv_go
);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_ARRAY = ADDR_W'(ARRAY_LO);

  function automatic akind_e classify(input logic [ADDR_W-1:0] a);
    if (a == A_STAT)       return AK_STATUS;
    else if (a >= A_ARRAY) return AK_ARRAY;
    else                   return AK_CTRL;
  endfunction

  akind_e kind;
  logic   permit;

  always_comb begin
    kind = classify(addr);
    unique case (kind)
      AK_STATUS: permit = 1'b1;
      AK_ARRAY:  permit = we_q;
      default:   permit = we_q & ctl_q;
    endcase
  end

  assign stat_wr   = wr & (kind == AK_STATUS);
  assign ack       = wr & permit;
  assign nv_go     = ack & (kind != AK_STATUS);
  assign ctl_wr_ok = ack & (kind == AK_CTRL);
endmodule

// File: rtl/sg_latches.sv
module sg_latches
  import status_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_wr,
  input  logic [DW-1:0] wdata,
  input  logic          nv_done,
  input  logic          ctl_wr_ok,
  output logic          we_q,
  output logic          ctl_q,
  output logic          pfail_q
);
  wpat_e pat;
  logic  we_set, we_clr, ctl_set, ctl_clr;

  assign pat     = decode_pat(wdata);
  assign we_set  = stat_wr & (pat == PAT_WE_ON);
  assign we_clr  = stat_wr & (pat == PAT_CLEAR);
  assign ctl_set = stat_wr & (pat == PAT_BOTH_ON) & we_q;
  assign ctl_clr = we_clr | nv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      ctl_q   <= 1'b0;
      pfail_q <= 1'b1;
    end else begin
      if (we_clr)      we_q <= 1'b0;
      else if (we_set) we_q <= 1'b1;
      if (ctl_clr)      ctl_q <= 1'b0;
      else if (ctl_set) ctl_q <= 1'b1;
      if (ctl_wr_ok) pfail_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sg_alarm_bank.sv
module sg_alarm_bank
  import status_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               open_rd,
  input  logic               close_rd,
  input  logic [NUM_ALM-1:0] hit,
  output logic [NUM_ALM-1:0] flags_q
);
  logic               rd_live;
  logic [NUM_ALM-1:0] snap_q;
  logic               close_live;

  assign close_live = close_rd & rd_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_live <= 1'b0;
    else if (open_rd)  rd_live <= 1'b1;
    else if (close_rd) rd_live <= 1'b0;
  end

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_alm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_q[i]  <= 1'b0;
        flags_q[i] <= 1'b0;
      end else begin
        if (open_rd) snap_q[i] <= flags_q[i];
        flags_q[i] <= alarm_next(flags_q, snap_q, hit, close_live)[i];
      end
    end
  end
endmodule

// File: rtl/status_guard.sv
module status_guard
  import status_guard_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] STAT_ADDR = 12'h03F,
  parameter logic [11:0] ARRAY_LO  = 12'h040
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               rd_start,
  input  logic               rd_end,
  input  logic [NUM_ALM-1:0] alarm_hit,
  input  logic               on_backup,
  input  logic               nv_done,
  output logic [DW-1:0]      stat_q,
  output logic               wr_ack,
  output logic               nv_start,
  output logic               we_open,
  output logic               ctl_open
);
  logic               stat_wr, ctl_wr_ok;
  logic               we_q, ctl_q, pfail_q, backup_q, stat_rd_open;
  logic [NUM_ALM-1:0] alm_q;

  assign stat_rd_open = rd_start & (reg_addr == ADDR_W'(STAT_ADDR));

  sg_access_gate #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ARRAY_LO(ARRAY_LO)) u_gate (
    .addr(reg_addr), .wr(reg_wr), .we_q(we_q), .ctl_q(ctl_q),
    .stat_wr(stat_wr), .ctl_wr_ok(ctl_wr_ok), .ack(wr_ack), .nv_go(nv_start)
  );

  sg_latches u_latch (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .wdata(reg_wdata),
    .nv_done(nv_done), .ctl_wr_ok(ctl_wr_ok),
    .we_q(we_q), .ctl_q(ctl_q), .pfail_q(pfail_q)
  );

  sg_alarm_bank u_alm (
    .clk(clk), .rst_n(rst_n), .open_rd(stat_rd_open), .close_rd(rd_end),
    .hit(alarm_hit), .flags_q(alm_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) backup_q <= 1'b0;
    else        backup_q <= on_backup;
  end

  assign stat_q   = pack_status(backup_q, alm_q, ctl_q, we_q, pfail_q);
  assign we_open  = we_q;
  assign ctl_open = we_q & ctl_q;
endmodule

// File: rtl/status_guard_checker.sv
module status_guard_checker
  import status_guard_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] STAT_ADDR = 12'h03F,
  parameter logic [11:0] ARRAY_LO  = 12'h040
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic [NUM_ALM-1:0] alarm_hit,
  input logic               on_backup,
  input logic               nv_done,
  input logic [DW-1:0]      stat_q,
  input logic               wr_ack,
  input logic               nv_start
);
  logic is_stat, is_arr;
  assign is_stat = (reg_addr == ADDR_W'(STAT_ADDR));
  assign is_arr  = (reg_addr >= ADDR_W'(ARRAY_LO));

  a_r2_backup_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_q[B_BACKUP] == $past(on_backup));
  a_r4_ctl_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[B_CTL] |-> stat_q[B_WE]);
  a_r5_done_drops_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    nv_done |=> !stat_q[B_CTL]);
  a_r6_status_no_nv: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && is_stat) |-> (wr_ack && !nv_start));
  a_r7_array_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && is_arr && !stat_q[B_WE]) |-> (!wr_ack && !nv_start));
  a_r8_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !is_stat && !is_arr && !(stat_q[B_WE] && stat_q[B_CTL])) |-> !wr_ack);
  a_r9_alarm0_sets: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit[0] |=> stat_q[B_ALM0]);
  a_r9_alarm1_sets: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit[1] |=> stat_q[B_ALM1]);
  a_r11_pfail_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[B_PFAIL] |=> !stat_q[B_PFAIL]);
  a_r12_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[4:3] == 2'b00);
endmodule

bind status_guard status_guard_checker #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .ARRAY_LO(ARRAY_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .alarm_hit(alarm_hit), .on_backup(on_backup), .nv_done(nv_done),
  .stat_q(stat_q), .wr_ack(wr_ack), .nv_start(nv_start)
);

// File: tb/status_guard_bench.sv
`timescale 1ns/1ps
module status_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        rd_start = 1'b0, rd_end = 1'b0;
  logic [1:0]  alarm_hit = '0;
  logic        on_backup = 1'b0, nv_done = 1'b0;
  logic [7:0]  stat_q;
  logic        wr_ack, nv_start, we_open, ctl_open;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  status_guard u_status_guard (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .rd_start(rd_start), .rd_end(rd_end),
    .alarm_hit(alarm_hit), .on_backup(on_backup), .nv_done(nv_done),
    .stat_q(stat_q), .wr_ack(wr_ack), .nv_start(nv_start),
    .we_open(we_open), .ctl_open(ctl_open)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 0; rd_start = 0; rd_end = 0; alarm_hit = 0; nv_done = 0;
    tick(); tick(); rst_n = 1'b1; tick();
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; #1;
    tick(); reg_wr = 1'b0;
  endtask

  // state: 0 = none, 1 = write latch, 2 = both latches
  task automatic reach(input int st);
    if (st >= 1) wr(12'h03F, 8'h02);
    if (st >= 2) wr(12'h03F, 8'h06);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset value", stat_q, 8'h01);
    check("R1 latch outputs", {6'b0, we_open, ctl_open}, 8'h00);

    // R3 R4 R6: every status byte from every reachable latch state
    for (int st = 0; st < 3; st++) begin
      for (int v = 0; v < 256; v++) begin
        logic w, c, ew, ec;
        do_reset();
        reach(st);
        w = (st >= 1); c = (st >= 2);
        ew = w; ec = c;
        if (v == 8'h00) begin ew = 0; ec = 0; end
        else if (v == 8'h02) ew = 1;
        else if (v == 8'h06 && w) ec = 1;
        reg_addr = 12'h03F; reg_wdata = 8'(v); reg_wr = 1'b1; #1;
        check("R6 status ack/nv", {6'b0, wr_ack, nv_start}, 8'h02);
        tick(); reg_wr = 1'b0;
        check("R3 R4 latches after status write", {5'b0, stat_q[2:0]}, {5'b0, ec, ew, 1'b1});
        check("R12 zero bits", {6'b0, stat_q[4:3]}, 8'h00);
      end
    end

    // R7 R8 R11: access sweep over address kinds and latch states
    for (int st = 0; st < 3; st++) begin
      for (int k = 0; k < 7; k++) begin
        logic [11:0] a;
        logic ea, en, is_stat, is_arr, w, c;
        a = (k == 0) ? 12'h000 : (k == 1) ? 12'h010 : (k == 2) ? 12'h03E :
            (k == 3) ? 12'h03F : (k == 4) ? 12'h040 : (k == 5) ? 12'h100 : 12'hFFF;
        do_reset();
        reach(st);
        w = (st >= 1); c = (st >= 2);
        is_stat = (a == 12'h03F); is_arr = (a >= 12'h040);
        ea = is_stat ? 1'b1 : is_arr ? w : (w & c);
        en = ea & !is_stat;
        reg_addr = a; reg_wdata = 8'hA5; reg_wr = 1'b1; #1;
        check(is_arr ? "R7 array ack/nv" : is_stat ? "R6 status ack/nv" : "R8 ctrl ack/nv",
              {6'b0, wr_ack, nv_start}, {6'b0, ea, en});
        tick(); reg_wr = 1'b0;
        check("R11 power-fail flag", {7'b0, stat_q[0]}, {7'b0, !(ea && !is_stat && !is_arr)});
      end
    end

    // R11: flag stays low, even through later latch traffic
    do_reset(); reach(2); wr(12'h020, 8'h11); wr(12'h03F, 8'h00); wr(12'h03F, 8'h01);
    check("R11 flag not set again", {7'b0, stat_q[0]}, 8'h00);

    // R5: nv_done drops control latch, keeps write latch
    do_reset(); reach(2);
    check("R4 ctl_open after sequence", {7'b0, ctl_open}, 8'h01);
    nv_done = 1; tick(); nv_done = 0;
    check("R5 done clears ctl", {5'b0, stat_q[2:0]}, 8'h03);
    reg_addr = 12'h03F; reg_wdata = 8'h06; reg_wr = 1; nv_done = 1; tick(); reg_wr = 0; nv_done = 0;
    check("R5 done beats set", {5'b0, stat_q[2:0]}, 8'h03);

    // R2: backup bit follows input, ignores writes
    do_reset();
    on_backup = 1; tick();
    check("R2 backup set", stat_q, 8'h81);
    wr(12'h03F, 8'h00);
    check("R2 write leaves backup", stat_q, 8'h81);
    on_backup = 0; tick();
    check("R2 backup clear", stat_q, 8'h01);

    // R9 R10: alarm set and snapshot clear
    do_reset();
    alarm_hit = 2'b01; tick(); alarm_hit = 0;
    check("R9 alarm0 set", stat_q, 8'h21);
    reg_addr = 12'h03F; rd_start = 1; tick(); rd_start = 0;
    alarm_hit = 2'b10; tick(); alarm_hit = 0;
    check("R9 alarm1 set during read", stat_q, 8'h61);
    rd_end = 1; tick(); rd_end = 0;
    check("R10 only snapshotted cleared", stat_q, 8'h41);
    rd_end = 1; tick(); rd_end = 0;
    check("R10 rd_end without read", stat_q, 8'h41);
    rd_start = 1; tick(); rd_start = 0;
    rd_end = 1; alarm_hit = 2'b10; tick(); rd_end = 0; alarm_hit = 0;
    check("R10 hit on close survives", stat_q, 8'h41);
    rd_start = 1; tick(); rd_start = 0; rd_end = 1; tick(); rd_end = 0;
    check("R10 full clear", stat_q, 8'h01);
    alarm_hit = 2'b11; tick(); alarm_hit = 0;
    reg_addr = 12'h010; rd_start = 1; tick(); rd_start = 0; rd_end = 1; tick(); rd_end = 0;
    check("R10 read elsewhere keeps flags", stat_q, 8'h61);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule